// File: doc/BRIEF.md
# E1 Transmit CAS Signaling Inserter

This block sits in the 2.048 Mbit/s E1 transmit serial path, one bit per bit-clock enable. It tracks the bit, timeslot and frame position of the outgoing stream with its own counters, which an external multiframe sync strobe realigns. It rewrites timeslot 16 with channel-associated signaling (CAS). Every other timeslot passes through with one bit of delay.

Each channel's four ABCD bits can come from three places: the incoming PCM data itself, a serial signaling input that runs bit-aligned with the PCM data, or a bank of per-channel signaling registers. A 32-bit blocking mask makes the choice for each channel. When the blocking function is selected, the frame 0 timeslot 16 byte comes from a dedicated byte input. That byte holds the multiframe alignment word, the remote multiframe alarm and the spare bits.

Top module: `e1_cas_inserter`

## Requirements
- R1: While reset is asserted, `ser_out` is 0. After reset, the first enabled bit presented without a sync strobe is bit 0 of timeslot 0 of frame 0.
- R2: Each enabled input bit appears on `ser_out` after the rising edge that samples it, so the latency is one bit period. Bits outside timeslot 16 are copied unchanged in every mode.
- R3: While `bit_en` is low, `ser_out` and the position counters hold their values, and input changes have no effect.
- R4: A frame is 256 bits: 32 timeslots of 8 bits, MSB first, with timeslot = bit index / 8. A multiframe is 16 frames. A `mf_sync` pulse together with `bit_en` marks the current bit as frame 0, bit 0. Without a pulse, the counters wrap on their own.
- R5: With `blk_sel`=0 and `hw_ins_en`=0, timeslot 16 passes through unchanged.
- R6: With `blk_sel`=0 and `hw_ins_en`=1, every timeslot 16 bit, frame 0 included, is taken from `sig_in`.
- R7: With `blk_sel`=1, the timeslot 16 bits of frame 0 are `align_byte[7]` first down to `align_byte[0]`.
- R8: With `blk_sel`=1, in frame f (1..15) the first four bits of timeslot 16 carry channel f and the last four carry channel f+16. When `blk_mask[c]`=1, channel c sends `sig_regs[4c+3]` (A), `sig_regs[4c+2]` (B), `sig_regs[4c+1]` (C) and `sig_regs[4c]` (D), in that order.
- R9: With `blk_sel`=1 and `blk_mask[c]`=0, the nibble of channel c comes from `ser_in` when `hw_ins_en`=0 and from `sig_in` when `hw_ins_en`=1. Each nibble follows its own mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per E1 bit |
| mf_sync | input | 1 | Multiframe strobe, marks the current bit as frame 0 bit 0 |
| ser_in | input | 1 | Incoming PCM serial data |
| sig_in | input | 1 | Serial signaling input, bit-aligned with ser_in |
| hw_ins_en | input | 1 | Take streamed signaling from sig_in instead of ser_in |
| blk_sel | input | 1 | Enable per-channel blocking and the frame 0 byte |
| blk_mask | input | 32 | Per-channel source: 1 = register, 0 = stream |
| sig_regs | input | 128 | ABCD per channel, channel c at [4c+3:4c] |
| align_byte | input | 8 | Frame 0 timeslot 16 byte (alignment, alarm, spare) |
| ser_out | output | 1 | Outgoing PCM serial data |

## Verification
Every result is due one bit period after the enabled edge that samples it. The bench drives each bit on a falling edge and compares `ser_out` on the next falling edge, so the rising edge in between is the only register on the path. The bench keeps its own frame and bit position, which it resets whenever it pulses the sync strobe. From that position it derives the expected bit arithmetically. During stall periods the bench compares `ser_out` one falling edge later, against the value that was held.

// File: rtl/e1_cas_pkg.sv
package e1_cas_pkg;
  // Source chosen for the bit currently presented
  typedef enum logic [2:0] {
    SRC_SER   = 3'd0,
    SRC_SIG   = 3'd1,
    SRC_REG   = 3'd2,
    SRC_ALIGN = 3'd3
  } ts16_src_e;
endpackage

// File: rtl/e1_pos_counter.sv
module e1_pos_counter #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 32,
  parameter int FRAMES = 16,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int TS_W  = $clog2(SLOTS),
  localparam int FR_W  = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            mf_sync,
  output logic [FR_W-1:0] cur_frame,
  output logic [TS_W-1:0] cur_ts,
  output logic [BIT_W-1:0] cur_bit
);
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [TS_W-1:0]  ts_q, ts_d;
  logic [FR_W-1:0]  fr_q, fr_d;

  // Position of the bit on the inputs now
  always_comb begin
    if (mf_sync) begin
      cur_bit   = '0;
      cur_ts    = '0;
      cur_frame = '0;
    end else begin
      cur_bit   = bit_q;
      cur_ts    = ts_q;
      cur_frame = fr_q;
    end
  end

  // Position of the following bit
  always_comb begin
    bit_d = cur_bit + BIT_W'(1);
    ts_d  = cur_ts;
    fr_d  = cur_frame;
    if (cur_bit == BIT_W'(BYTE_W - 1)) begin
      bit_d = '0;
      if (cur_ts == TS_W'(SLOTS - 1)) begin
        ts_d = '0;
        fr_d = (cur_frame == FR_W'(FRAMES - 1)) ? '0 : cur_frame + FR_W'(1);
      end else begin
        ts_d = cur_ts + TS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      ts_q  <= '0;
      fr_q  <= '0;
    end else if (bit_en) begin
      bit_q <= bit_d;
      ts_q  <= ts_d;
      fr_q  <= fr_d;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(bit_q) && $stable(ts_q) && $stable(fr_q)));

  assert_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mf_sync) |=> (bit_q == BIT_W'(1) && ts_q == '0 && fr_q == '0));

  assert_frame_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !mf_sync && bit_q == BIT_W'(BYTE_W - 1) && ts_q == TS_W'(SLOTS - 1))
    |=> (bit_q == '0 && ts_q == '0 &&
         fr_q == (($past(fr_q) == FR_W'(FRAMES - 1)) ? '0 : $past(fr_q) + FR_W'(1))));
endmodule

// File: rtl/e1_ts16_select.sv
module e1_ts16_select
  import e1_cas_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 32,
  parameter int FRAMES = 16,
  parameter int ABCD_W = 4,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int FR_W  = $clog2(FRAMES),
  localparam int CH_W  = $clog2(SLOTS),
  localparam int NB_W  = $clog2(ABCD_W),
  localparam int IX_W  = $clog2(SLOTS * ABCD_W)
) (
  input  logic [FR_W-1:0]         cur_frame,
  input  logic [BIT_W-1:0]        cur_bit,
  input  logic                    ser_in,
  input  logic                    sig_in,
  input  logic                    hw_ins_en,
  input  logic                    blk_sel,
  input  logic [SLOTS-1:0]        blk_mask,
  input  logic [SLOTS*ABCD_W-1:0] sig_regs,
  input  logic [BYTE_W-1:0]       align_byte,
  output logic                    ts16_bit
);
  ts16_src_e        src;
  logic [CH_W-1:0]  chan;
  logic [NB_W-1:0]  nib;
  logic [IX_W-1:0]  reg_idx;
  logic [BIT_W-1:0] align_idx;

  // First nibble is channel f, second nibble is channel f + SLOTS/2
  always_comb begin
    if (int'(cur_bit) < ABCD_W) chan = CH_W'(cur_frame);
    else                        chan = CH_W'(cur_frame) + CH_W'(SLOTS / 2);
    nib       = NB_W'(cur_bit);
    reg_idx   = IX_W'(chan) * IX_W'(ABCD_W) + IX_W'(ABCD_W - 1) - IX_W'(nib);
    align_idx = BIT_W'(BYTE_W - 1) - cur_bit;
  end

  always_comb begin
    src = hw_ins_en ? SRC_SIG : SRC_SER;
    if (blk_sel) begin
      if (cur_frame == '0)    src = SRC_ALIGN;
      else if (blk_mask[chan]) src = SRC_REG;
    end
  end

  always_comb begin
    case (src)
      SRC_SIG:   ts16_bit = sig_in;
      SRC_REG:   ts16_bit = sig_regs[reg_idx];
      SRC_ALIGN: ts16_bit = align_byte[align_idx];
      default:   ts16_bit = ser_in;
    endcase
  end
endmodule

// File: rtl/e1_cas_inserter.sv
module e1_cas_inserter #(
  parameter int BYTE_W   = 8,
  parameter int SLOTS    = 32,
  parameter int FRAMES   = 16,
  parameter int ABCD_W   = 4,
  parameter int SIG_SLOT = 16,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int TS_W  = $clog2(SLOTS),
  localparam int FR_W  = $clog2(FRAMES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    mf_sync,
  input  logic                    ser_in,
  input  logic                    sig_in,
  input  logic                    hw_ins_en,
  input  logic                    blk_sel,
  input  logic [SLOTS-1:0]        blk_mask,
  input  logic [SLOTS*ABCD_W-1:0] sig_regs,
  input  logic [BYTE_W-1:0]       align_byte,
  output logic                    ser_out
);
  logic [FR_W-1:0]  cur_frame;
  logic [TS_W-1:0]  cur_ts;
  logic [BIT_W-1:0] cur_bit;
  logic             ts16_bit;
  logic             in_sig_slot;
  logic             out_d, out_q;

  e1_pos_counter #(
    .BYTE_W (BYTE_W),
    .SLOTS  (SLOTS),
    .FRAMES (FRAMES)
  ) i_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .mf_sync   (mf_sync),
    .cur_frame (cur_frame),
    .cur_ts    (cur_ts),
    .cur_bit   (cur_bit)
  );

  e1_ts16_select #(
    .BYTE_W (BYTE_W),
    .SLOTS  (SLOTS),
    .FRAMES (FRAMES),
    .ABCD_W (ABCD_W)
  ) i_sel (
    .cur_frame  (cur_frame),
    .cur_bit    (cur_bit),
    .ser_in     (ser_in),
    .sig_in     (sig_in),
    .hw_ins_en  (hw_ins_en),
    .blk_sel    (blk_sel),
    .blk_mask   (blk_mask),
    .sig_regs   (sig_regs),
    .align_byte (align_byte),
    .ts16_bit   (ts16_bit)
  );

  always_comb begin
    in_sig_slot = (cur_ts == TS_W'(SIG_SLOT));
    out_d       = in_sig_slot ? ts16_bit : ser_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (bit_en) out_q <= out_d;
  end

  assign ser_out = out_q;

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && cur_ts != TS_W'(SIG_SLOT)) |=> (ser_out == $past(ser_in)));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && blk_sel && cur_ts == TS_W'(SIG_SLOT) && cur_frame == '0)
    |=> (ser_out == $past(align_byte[BIT_W'(BYTE_W - 1) - cur_bit])));

  assert_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !blk_sel && !hw_ins_en) |=> (ser_out == $past(ser_in)));
endmodule

// File: tb/test_e1_cas_inserter.sv
module test_e1_cas_inserter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_en = 1'b0;
  logic         mf_sync = 1'b0;
  logic         ser_in = 1'b0;
  logic         sig_in = 1'b0;
  logic         hw_ins_en = 1'b0;
  logic         blk_sel = 1'b0;
  logic [31:0]  blk_mask = '0;
  logic [127:0] sig_regs = '0;
  logic [7:0]   align_byte = '0;
  logic         ser_out;

  int errors = 0;
  int checks = 0;
  int bpos = 0;
  int bfr = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  e1_cas_inserter i_e1_cas_inserter (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mf_sync(mf_sync),
    .ser_in(ser_in), .sig_in(sig_in), .hw_ins_en(hw_ins_en),
    .blk_sel(blk_sel), .blk_mask(blk_mask), .sig_regs(sig_regs),
    .align_byte(align_byte), .ser_out(ser_out)
  );

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s frame=%0d bit=%0d: actual=%b expected=%b", tag, bfr, bpos, act, exp);
    end
  endtask

  // Expected output bit and the requirement that covers it
  task automatic model(input logic s, input logic g, output logic e, output string tag);
    int ts, b, c;
    ts = bpos / 8;
    b  = bpos % 8;
    if (ts != 16) begin
      e = s; tag = "R2";
    end else if (!blk_sel) begin
      e = hw_ins_en ? g : s; tag = hw_ins_en ? "R6" : "R5";
    end else if (bfr == 0) begin
      e = align_byte[7 - b]; tag = "R7";
    end else begin
      c = (b < 4) ? bfr : bfr + 16;
      if (blk_mask[c]) begin
        e = sig_regs[c * 4 + 3 - (b % 4)]; tag = "R8";
      end else begin
        e = hw_ins_en ? g : s; tag = "R9";
      end
    end
  endtask

  // Called on a falling edge; returns on the next falling edge after checking
  task automatic step(input logic sync);
    logic s, g, e;
    string tag;
    s = 1'($urandom);
    g = 1'($urandom);
    if (sync) begin bpos = 0; bfr = 0; end
    mf_sync = sync;
    ser_in  = s;
    sig_in  = g;
    bit_en  = 1'b1;
    model(s, g, e, tag);
    @(negedge clk);
    check(sync ? {tag, "/R4"} : tag, ser_out, e);
    bpos++;
    if (bpos == 256) begin bpos = 0; bfr = (bfr + 1) % 16; end
  endtask

  task automatic run_mf(input int n_bits, input logic first_sync);
    for (int i = 0; i < n_bits; i++) step(first_sync && i == 0);
    mf_sync = 1'b0;
  endtask

  task automatic stall(input int n);
    logic held;
    held = ser_out;
    bit_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      ser_in = ~ser_in;
      sig_in = ~sig_in;
      mf_sync = 1'b1;
      @(negedge clk);
      check("R3", ser_out, held);
    end
    mf_sync = 1'b0;
  endtask

  initial begin
    sig_regs   = {$urandom, $urandom, $urandom, $urandom};
    align_byte = 8'b0000_1011;
    blk_mask   = 32'hA5C3_96E1;
    repeat (3) @(negedge clk);
    check("R1", ser_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", ser_out, 1'b0);

    // After reset, without sync, position starts at frame 0 bit 0
    blk_sel = 1'b1;
    run_mf(256 * 2, 1'b0);

    // Open passthrough
    blk_sel = 1'b0; hw_ins_en = 1'b0;
    run_mf(4096, 1'b1);
    // Timeslot 16 from sig_in
    hw_ins_en = 1'b1;
    run_mf(4096, 1'b1);
    // Blocking, streamed channels from ser_in; a stall just before timeslot 16
    blk_sel = 1'b1; hw_ins_en = 1'b0;
    run_mf(256 * 3 + 127, 1'b1);
    stall(4);
    run_mf(4096, 1'b0);
    // Blocking with sig_in for unmasked channels, other mask and regs
    hw_ins_en = 1'b1;
    blk_mask  = 32'h5A3C_C369;
    sig_regs  = {$urandom, $urandom, $urandom, $urandom};
    align_byte = 8'b1111_0100;
    run_mf(4096, 1'b1);
    // Sync in the middle of a frame realigns
    run_mf(256 * 5 + 77, 1'b0);
    run_mf(4096, 1'b1);
    // All masked, all streamed
    blk_mask = '1;
    run_mf(4096, 1'b1);
    blk_mask = '0;
    run_mf(4096, 1'b1);

    // Reset mid-stream returns output to 0
    rst_n = 1'b0;
    bit_en = 1'b0;
    @(negedge clk);
    check("R1", ser_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    bpos = 0; bfr = 0;
    run_mf(256, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule